// File: doc/BRIEF.md
# Code-guessing game controller

This block runs one code-guessing game. A hidden code of four digits, each from 0 to 5, is built from a free-running 8-bit count while the first guess is keyed in. Key presses arrive as 3-bit codes with a one-cycle strobe. Codes 0 to 5 are guess digits, and codes 6 and 7 restart the game. Each accepted digit is echoed as a display request. The fourth digit of a guess hands the guess, together with the hidden code, to an external scorer.

The scorer answers with a feedback byte. The controller presents that byte to the feedback display with a one-cycle write pulse, counts the guesses used, and issues further display requests: a line break after the third guess, a win or lose message, and a request to reveal the hidden code. After a win or a loss only a restart key has any effect.

A key that arrives while a score is outstanding, or while an end message is being issued, is held in a one-deep slot. It is handled once the controller is ready again.

Top module: `code_guess_ctrl`

## Requirements
- R1: A strobed key above 5 restarts the game in the next cycle from any state. It clears the digit position, the guess count, the end state and the hidden-code-present flag, so the next guess draws a fresh hidden code. The restart key itself produces no display request and no score request.
- R2: In the win or lose end state a digit key produces no display request, no score request and no feedback write, and it leaves `fb_o` unchanged.
- R3: While no hidden code exists, the digit accepted at position p (0 to 3) also stores hidden digit p as bits [10:8] of `rnd_i` × 6, using the `rnd_i` value of that cycle. Later guesses leave the hidden code unchanged. `secret_o` carries hidden digit p in bits [3p+2:3p].
- R4: Each accepted digit yields, one cycle after it is taken, a display request with op 0 (echo) and the digit on `disp_dig_o`. Every other op shows 0 on `disp_dig_o`.
- R5: Digits fill positions 0 to 3 in order, and `guess_o` carries position p in bits [3p+2:3p]. From the cycle after the fourth digit, `score_req_o` stays high until `score_vld_i` is seen, and the next digit starts again at position 0.
- R6: For each `score_vld_i` seen while a score is requested, `fb_o` takes `score_i` and `fb_we_o` is high for exactly one cycle, both in the following cycle.
- R7: A score equal to 0xF0 issues op 2 (win) in the same cycle as the feedback write, then op 4 (reveal) in the next cycle, and then the end state is entered.
- R8: A non-winning score that brings the guess count to 3 issues op 1 (line break) with the feedback write.
- R9: A non-winning score that brings the guess count to 6 issues op 3 (lose) with the feedback write, then op 4 (reveal) in the next cycle, and then the end state is entered.
- R10: A digit strobe that arrives while a score is outstanding is processed exactly once, after the score returns, and is echoed after that score's feedback write.
- R11: After reset no display request, no feedback write and no score request is active, and `fb_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_i | input | 3 | Key code: 0-5 digit, 6-7 restart |
| key_vld_i | input | 1 | One-cycle key strobe |
| rnd_i | input | 8 | Free-running count used as random source |
| score_vld_i | input | 1 | Scorer result valid |
| score_i | input | 8 | Scorer feedback byte |
| score_req_o | output | 1 | Guess waiting for a score |
| guess_o | output | 12 | Current guess digits, position 0 in the low bits |
| secret_o | output | 12 | Hidden code digits, position 0 in the low bits |
| fb_o | output | 8 | Latest feedback byte |
| fb_we_o | output | 1 | One-cycle feedback write pulse |
| disp_vld_o | output | 1 | Display request valid |
| disp_op_o | output | 3 | Request: 0 echo, 1 line break, 2 win, 3 lose, 4 reveal |
| disp_dig_o | output | 3 | Digit to echo |

## Verification
The first game loses. It applies six wrong guesses, and the guesses use different count values, which separates a code drawn only once from one redrawn on every guess. The third guess probes the line break, the sixth guess probes the lose-and-reveal pair, and one digit is keyed during an outstanding score to show deferred handling. The second game starts with a restart in mid-guess and then ends in a win on the fourth guess. A line break on its third guess shows that the count was cleared, and the hidden code is redrawn from new count values. Digit keys sent in the end state, and a scorer latency of zero to three cycles, test that nothing leaks from an ignored press or a late answer.

// File: rtl/cg_pkg.sv
package cg_pkg;
  typedef enum logic [2:0] {
    DISP_ECHO    = 3'd0,
    DISP_NEWLINE = 3'd1,
    DISP_WIN     = 3'd2,
    DISP_LOSE    = 3'd3,
    DISP_REVEAL  = 3'd4
  } disp_op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SCORE  = 2'd1,
    ST_REVEAL = 2'd2,
    ST_END    = 2'd3
  } round_st_e;
endpackage

// File: rtl/cg_key_gate.sv
module cg_key_gate #(
  parameter int KEY_W = 3,
  parameter int SYMS  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [KEY_W-1:0] key_i,
  input  logic             key_vld_i,
  input  logic             busy_i,
  input  logic             drop_i,
  output logic             game_rst_o,
  output logic             dig_vld_o,
  output logic [KEY_W-1:0] dig_o
);
  localparam logic [KEY_W-1:0] TOP_SYM = KEY_W'(SYMS - 1);

  logic             is_rst;
  logic             new_dig;
  logic             pend_v_q;
  logic [KEY_W-1:0] pend_q;

  assign is_rst     = key_vld_i && (key_i > TOP_SYM);
  assign new_dig    = key_vld_i && !is_rst;
  assign game_rst_o = is_rst;
  // held key goes first; a new key behind it takes the slot
  assign dig_vld_o  = !busy_i && (pend_v_q || new_dig);
  assign dig_o      = pend_v_q ? pend_q : key_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q <= 1'b0;
      pend_q   <= '0;
    end else if (is_rst || drop_i) begin
      pend_v_q <= 1'b0;
    end else if (busy_i) begin
      if (new_dig) begin
        pend_v_q <= 1'b1;
        pend_q   <= key_i;
      end
    end else if (pend_v_q) begin
      if (new_dig) pend_q <= key_i;
      else         pend_v_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cg_code_store.sv
module cg_code_store #(
  parameter int KEY_W  = 3,
  parameter int DIGITS = 4,
  parameter int SYMS   = 6,
  parameter int RND_W  = 8,
  parameter int POS_W  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic                    draw_i,
  input  logic [POS_W-1:0]        pos_i,
  input  logic [KEY_W-1:0]        dig_i,
  input  logic [RND_W-1:0]        rnd_i,
  output logic [DIGITS*KEY_W-1:0] guess_o,
  output logic [DIGITS*KEY_W-1:0] secret_o
);
  localparam int PROD_W = RND_W + KEY_W;

  logic [PROD_W-1:0] prod;
  logic [KEY_W-1:0]  draw_dig;

  // scaled count: high part of rnd*SYMS lies in 0..SYMS-1
  assign prod     = PROD_W'(rnd_i) * PROD_W'(SYMS);
  assign draw_dig = prod[RND_W +: KEY_W];

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [KEY_W-1:0] guess_q;
    logic [KEY_W-1:0] code_q;
    logic             hit;

    assign hit = (pos_i == POS_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        guess_q <= '0;
        code_q  <= '0;
      end else begin
        if (wr_i && hit)   guess_q <= dig_i;
        if (draw_i && hit) code_q  <= draw_dig;
      end
    end

    assign guess_o[g*KEY_W +: KEY_W]  = guess_q;
    assign secret_o[g*KEY_W +: KEY_W] = code_q;
  end
endmodule

// File: rtl/cg_round_ctrl.sv
module cg_round_ctrl
  import cg_pkg::*;
#(
  parameter int              KEY_W      = 3,
  parameter int              DIGITS     = 4,
  parameter int              FB_W       = 8,
  parameter int              MAX_GUESS  = 6,
  parameter int              LINE_GUESS = 3,
  parameter int              POS_W      = 2,
  parameter logic [FB_W-1:0] WIN_FB     = 'hF0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             game_rst_i,
  input  logic             dig_vld_i,
  input  logic [KEY_W-1:0] dig_i,
  input  logic             score_vld_i,
  input  logic [FB_W-1:0]  score_i,
  output logic             busy_o,
  output logic             drop_o,
  output logic             wr_o,
  output logic             draw_o,
  output logic [POS_W-1:0] pos_o,
  output logic             score_req_o,
  output logic [FB_W-1:0]  fb_o,
  output logic             fb_we_o,
  output logic             disp_vld_o,
  output logic [2:0]       disp_op_o,
  output logic [KEY_W-1:0] disp_dig_o
);
  localparam int              CNT_W    = $clog2(MAX_GUESS + 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(DIGITS - 1);
  localparam logic [CNT_W-1:0] LOSE_CNT = CNT_W'(MAX_GUESS);
  localparam logic [CNT_W-1:0] LINE_CNT = CNT_W'(LINE_GUESS);

  round_st_e        st_q;
  logic [POS_W-1:0] pos_q;
  logic             have_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic [FB_W-1:0]  fb_q;
  logic             fb_we_q;
  logic             dv_q;
  disp_op_e         dop_q;
  logic [KEY_W-1:0] ddig_q;
  logic             accept;

  assign accept  = (st_q == ST_IDLE) && dig_vld_i && !game_rst_i;
  assign cnt_inc = cnt_q + CNT_W'(1);

  assign busy_o      = (st_q == ST_SCORE) || (st_q == ST_REVEAL);
  assign drop_o      = (st_q == ST_END);
  assign wr_o        = accept;
  assign draw_o      = accept && !have_q;
  assign pos_o       = pos_q;
  assign score_req_o = (st_q == ST_SCORE);
  assign fb_o        = fb_q;
  assign fb_we_o     = fb_we_q;
  assign disp_vld_o  = dv_q;
  assign disp_op_o   = dop_q;
  assign disp_dig_o  = ddig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      pos_q   <= '0;
      have_q  <= 1'b0;
      cnt_q   <= '0;
      fb_q    <= '0;
      fb_we_q <= 1'b0;
      dv_q    <= 1'b0;
      dop_q   <= DISP_ECHO;
      ddig_q  <= '0;
    end else begin
      fb_we_q <= 1'b0;
      dv_q    <= 1'b0;
      dop_q   <= DISP_ECHO;
      ddig_q  <= '0;
      if (game_rst_i) begin
        st_q   <= ST_IDLE;
        pos_q  <= '0;
        have_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        unique case (st_q)
          ST_IDLE: begin
            if (accept) begin
              dv_q   <= 1'b1;
              ddig_q <= dig_i;
              if (pos_q == LAST_POS) begin
                pos_q  <= '0;
                have_q <= 1'b1;
                st_q   <= ST_SCORE;
              end else begin
                pos_q <= pos_q + 1'b1;
              end
            end
          end
          ST_SCORE: begin
            if (score_vld_i) begin
              fb_q    <= score_i;
              fb_we_q <= 1'b1;
              if (score_i == WIN_FB) begin
                dv_q  <= 1'b1;
                dop_q <= DISP_WIN;
                st_q  <= ST_REVEAL;
              end else begin
                cnt_q <= cnt_inc;
                if (cnt_inc == LOSE_CNT) begin
                  dv_q  <= 1'b1;
                  dop_q <= DISP_LOSE;
                  st_q  <= ST_REVEAL;
                end else begin
                  if (cnt_inc == LINE_CNT) begin
                    dv_q  <= 1'b1;
                    dop_q <= DISP_NEWLINE;
                  end
                  st_q <= ST_IDLE;
                end
              end
            end
          end
          ST_REVEAL: begin
            dv_q  <= 1'b1;
            dop_q <= DISP_REVEAL;
            st_q  <= ST_END;
          end
          ST_END: ;
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/code_guess_ctrl.sv
module code_guess_ctrl #(
  parameter int              KEY_W      = 3,
  parameter int              DIGITS     = 4,
  parameter int              SYMS       = 6,
  parameter int              RND_W      = 8,
  parameter int              FB_W       = 8,
  parameter int              MAX_GUESS  = 6,
  parameter int              LINE_GUESS = 3,
  parameter logic [FB_W-1:0] WIN_FB     = 'hF0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [KEY_W-1:0]        key_i,
  input  logic                    key_vld_i,
  input  logic [RND_W-1:0]        rnd_i,
  input  logic                    score_vld_i,
  input  logic [FB_W-1:0]         score_i,
  output logic                    score_req_o,
  output logic [DIGITS*KEY_W-1:0] guess_o,
  output logic [DIGITS*KEY_W-1:0] secret_o,
  output logic [FB_W-1:0]         fb_o,
  output logic                    fb_we_o,
  output logic                    disp_vld_o,
  output logic [2:0]              disp_op_o,
  output logic [KEY_W-1:0]        disp_dig_o
);
  localparam int POS_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;

  logic             game_rst;
  logic             dig_vld;
  logic [KEY_W-1:0] dig;
  logic             busy;
  logic             drop;
  logic             wr;
  logic             draw;
  logic [POS_W-1:0] pos;

  cg_key_gate #(
    .KEY_W (KEY_W),
    .SYMS  (SYMS)
  ) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_i      (key_i),
    .key_vld_i  (key_vld_i),
    .busy_i     (busy),
    .drop_i     (drop),
    .game_rst_o (game_rst),
    .dig_vld_o  (dig_vld),
    .dig_o      (dig)
  );

  cg_round_ctrl #(
    .KEY_W      (KEY_W),
    .DIGITS     (DIGITS),
    .FB_W       (FB_W),
    .MAX_GUESS  (MAX_GUESS),
    .LINE_GUESS (LINE_GUESS),
    .POS_W      (POS_W),
    .WIN_FB     (WIN_FB)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .game_rst_i  (game_rst),
    .dig_vld_i   (dig_vld),
    .dig_i       (dig),
    .score_vld_i (score_vld_i),
    .score_i     (score_i),
    .busy_o      (busy),
    .drop_o      (drop),
    .wr_o        (wr),
    .draw_o      (draw),
    .pos_o       (pos),
    .score_req_o (score_req_o),
    .fb_o        (fb_o),
    .fb_we_o     (fb_we_o),
    .disp_vld_o  (disp_vld_o),
    .disp_op_o   (disp_op_o),
    .disp_dig_o  (disp_dig_o)
  );

  cg_code_store #(
    .KEY_W  (KEY_W),
    .DIGITS (DIGITS),
    .SYMS   (SYMS),
    .RND_W  (RND_W),
    .POS_W  (POS_W)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .draw_i   (draw),
    .pos_i    (pos),
    .dig_i    (dig),
    .rnd_i    (rnd_i),
    .guess_o  (guess_o),
    .secret_o (secret_o)
  );
endmodule

// File: rtl/cg_ctrl_chk.sv
module cg_ctrl_chk
  import cg_pkg::*;
#(
  parameter int              KEY_W  = 3,
  parameter int              DIGITS = 4,
  parameter int              SYMS   = 6,
  parameter int              FB_W   = 8,
  parameter logic [FB_W-1:0] WIN_FB = 'hF0
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [KEY_W-1:0]        key_i,
  input logic                    key_vld_i,
  input logic                    score_vld_i,
  input logic                    score_req_o,
  input logic [FB_W-1:0]         fb_o,
  input logic                    fb_we_o,
  input logic                    disp_vld_o,
  input logic [2:0]              disp_op_o,
  input logic [KEY_W-1:0]        disp_dig_o,
  input logic [DIGITS*KEY_W-1:0] secret_o
);
  localparam logic [KEY_W-1:0] TOP_SYM = KEY_W'(SYMS - 1);

  logic rst_key;
  assign rst_key = key_vld_i && (key_i > TOP_SYM);

  // R1
  rst_key_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_key |=> !score_req_o && !disp_vld_o);

  // R6
  fb_we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_we_o |=> !fb_we_o);

  // R6
  fb_we_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_we_o |-> $past(score_vld_i && score_req_o));

  // R7
  win_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_we_o && fb_o == WIN_FB) |-> (disp_vld_o && disp_op_o == DISP_WIN));

  // R9
  reveal_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_vld_o && (disp_op_o == DISP_WIN || disp_op_o == DISP_LOSE) && !rst_key)
      |=> (disp_vld_o && disp_op_o == DISP_REVEAL));

  // R4
  echo_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_vld_o && disp_op_o != DISP_ECHO) |-> (disp_dig_o == '0));

  for (genvar g = 0; g < DIGITS; g++) begin : g_sec
    // R3
    secret_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      secret_o[g*KEY_W +: KEY_W] <= TOP_SYM);
  end
endmodule

bind code_guess_ctrl cg_ctrl_chk #(
  .KEY_W  (KEY_W),
  .DIGITS (DIGITS),
  .SYMS   (SYMS),
  .FB_W   (FB_W),
  .WIN_FB (WIN_FB)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .key_i       (key_i),
  .key_vld_i   (key_vld_i),
  .score_vld_i (score_vld_i),
  .score_req_o (score_req_o),
  .fb_o        (fb_o),
  .fb_we_o     (fb_we_o),
  .disp_vld_o  (disp_vld_o),
  .disp_op_o   (disp_op_o),
  .disp_dig_o  (disp_dig_o),
  .secret_o    (secret_o)
);

// File: tb/code_guess_ctrl_test.sv
module code_guess_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  key = '0;
  logic        key_vld = 1'b0;
  logic [7:0]  rnd = '0;
  logic        score_vld = 1'b0;
  logic [7:0]  score_val = '0;
  logic        score_req;
  logic [11:0] guess;
  logic [11:0] secret;
  logic [7:0]  fb;
  logic        fb_we;
  logic        disp_vld;
  logic [2:0]  disp_op;
  logic [2:0]  disp_dig;

  always #(CLK_PERIOD/2) clk = ~clk;

  code_guess_ctrl uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .key_i       (key),
    .key_vld_i   (key_vld),
    .rnd_i       (rnd),
    .score_vld_i (score_vld),
    .score_i     (score_val),
    .score_req_o (score_req),
    .guess_o     (guess),
    .secret_o    (secret),
    .fb_o        (fb),
    .fb_we_o     (fb_we),
    .disp_vld_o  (disp_vld),
    .disp_op_o   (disp_op),
    .disp_dig_o  (disp_dig)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit fin = 1'b0;

  logic [5:0] exp_disp[$];
  logic [7:0] exp_fb[$];

  int         m_pos = 0;
  int         m_cnt = 0;
  bit         m_have = 1'b0;
  bit         m_end = 1'b0;
  logic [2:0] m_code[4];
  logic [2:0] m_guess[4];
  logic [11:0] snap = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0:    return "R4";
      3'd1:    return "R8";
      3'd3:    return "R9";
      default: return "R7";
    endcase
  endfunction

  // monitor / scoreboard
  logic [5:0] mon_d;
  logic [7:0] mon_f;
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      if (disp_vld) begin
        if (exp_disp.size() == 0) begin
          chk(1'b0, "R2 unexpected display", {26'd0, disp_op, disp_dig}, 32'hFFFF);
        end else begin
          mon_d = exp_disp.pop_front();
          chk({disp_op, disp_dig} == mon_d, op_tag(mon_d[5:3]),
              {26'd0, disp_op, disp_dig}, {26'd0, mon_d});
        end
      end
      if (fb_we) begin
        if (exp_fb.size() == 0) begin
          chk(1'b0, "R6 unexpected write", {24'd0, fb}, 32'hFFFF);
        end else begin
          mon_f = exp_fb.pop_front();
          chk(fb == mon_f, "R6", {24'd0, fb}, {24'd0, mon_f});
        end
      end
    end
  end

  task automatic press(input logic [2:0] k, input logic [7:0] r, input bit push);
    if (k > 3'd5) begin
      m_pos = 0; m_cnt = 0; m_have = 1'b0; m_end = 1'b0;
    end else if (!m_end) begin
      if (push) exp_disp.push_back({3'd0, k});
      if (!m_have) m_code[m_pos] = 3'((int'(r) * 6) / 256);
      m_guess[m_pos] = k;
      m_pos++;
      if (m_pos == 4) begin
        m_pos  = 0;
        m_have = 1'b1;
        snap   = {m_guess[3], m_guess[2], m_guess[1], m_guess[0]};
      end
    end
    @(negedge clk);
    key = k; key_vld = 1'b1; rnd = r;
    @(negedge clk);
    key_vld = 1'b0;
  endtask

  task automatic score(input int lat, input bit has_pend, input logic [2:0] pend_k);
    int e;
    logic [7:0] sc;
    logic [11:0] sec_exp;
    sec_exp = {m_code[3], m_code[2], m_code[1], m_code[0]};
    chk(score_req === 1'b1, "R5 score request", {31'd0, score_req}, 1);
    chk(guess === snap, "R5 guess digits", {20'd0, guess}, {20'd0, snap});
    chk(secret === sec_exp, "R3 hidden code", {20'd0, secret}, {20'd0, sec_exp});
    e = 0;
    for (int i = 0; i < 4; i++) if (snap[i*3 +: 3] == m_code[i]) e++;
    sc = (e == 0) ? 8'h00 : 8'(8'hF0 << (4 - e));
    exp_fb.push_back(sc);
    if (sc == 8'hF0) begin
      exp_disp.push_back({3'd2, 3'd0});
      exp_disp.push_back({3'd4, 3'd0});
      m_end = 1'b1;
    end else begin
      m_cnt++;
      if (m_cnt == 6) begin
        exp_disp.push_back({3'd3, 3'd0});
        exp_disp.push_back({3'd4, 3'd0});
        m_end = 1'b1;
      end else if (m_cnt == 3) begin
        exp_disp.push_back({3'd1, 3'd0});
      end
    end
    // R10: held digit is echoed after this score's outcome
    if (has_pend) exp_disp.push_back({3'd0, pend_k});
    repeat (lat) @(negedge clk);
    score_vld = 1'b1; score_val = sc;
    @(negedge clk);
    score_vld = 1'b0;
  endtask

  task automatic g4(input logic [11:0] d, input logic [31:0] r, input int lat);
    for (int i = 0; i < 4; i++) press(d[i*3 +: 3], r[i*8 +: 8], 1'b1);
    score(lat, 1'b0, 3'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=0", 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11
    chk(disp_vld == 1'b0, "R11 display idle", {31'd0, disp_vld}, 0);
    chk(fb_we == 1'b0, "R11 write idle", {31'd0, fb_we}, 0);
    chk(score_req == 1'b0, "R11 no request", {31'd0, score_req}, 0);
    chk(fb == 8'h00, "R11 feedback zero", {24'd0, fb}, 0);

    // game A: code 0,1,3,5 drawn from 00,2B,80,FF
    g4({3'd5, 3'd5, 3'd5, 3'd5}, 32'hFF802B00, 0);
    g4({3'd4, 3'd3, 3'd1, 3'd0}, 32'h11223344, 1);  // R3: no redraw
    g4({3'd2, 3'd2, 3'd2, 3'd2}, 32'h99887766, 2);  // R8 line break
    for (int i = 0; i < 4; i++) press(3'd4, 8'h10, 1'b1);
    press(3'd1, 8'h20, 1'b0);                        // R10 held during score
    score(3, 1'b1, 3'd1);
    press(3'd0, 8'h01, 1'b1);
    press(3'd1, 8'h02, 1'b1);
    press(3'd2, 8'h03, 1'b1);
    score(1, 1'b0, 3'd0);
    g4({3'd4, 3'd4, 3'd4, 3'd4}, 32'h01020304, 0);  // R9 lose
    repeat (3) @(negedge clk);
    // R2: digit in end state
    press(3'd2, 8'h40, 1'b1);
    press(3'd3, 8'h41, 1'b1);
    repeat (4) @(negedge clk);
    chk(score_req == 1'b0, "R2 no request in end", {31'd0, score_req}, 0);
    chk(fb == 8'h00, "R2 feedback kept", {24'd0, fb}, 0);
    press(3'd6, 8'h00, 1'b1);                        // R1 restart

    // game B: restart mid-guess, code 1,3,1,4 from 55,AA,30,D5
    press(3'd3, 8'h00, 1'b1);
    press(3'd3, 8'h00, 1'b1);
    press(3'd7, 8'h00, 1'b1);                        // R1 mid-guess restart
    chk(score_req == 1'b0, "R1 quiet after restart", {31'd0, score_req}, 0);
    g4({3'd0, 3'd0, 3'd0, 3'd0}, 32'hD530AA55, 2);
    g4({3'd2, 3'd2, 3'd2, 3'd2}, 32'h0, 0);
    g4({3'd5, 3'd5, 3'd5, 3'd5}, 32'h0, 1);          // R8 after R1 count clear
    g4({3'd4, 3'd1, 3'd3, 3'd1}, 32'h0, 3);          // R7 win
    repeat (5) @(negedge clk);
    chk(secret == {3'd4, 3'd1, 3'd3, 3'd1}, "R7 revealed code", {20'd0, secret},
        {20'd0, 3'd4, 3'd1, 3'd3, 3'd1});
    chk(fb == 8'hF0, "R6 final feedback", {24'd0, fb}, 32'hF0);
    chk(exp_disp.size() == 0, "R4 displays drained", exp_disp.size(), 0);
    chk(exp_fb.size() == 0, "R6 writes drained", exp_fb.size(), 0);
    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule